// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-visible register file and chain sequencer for a single descriptor-chaining DMA channel. Software writes the address of the first descriptor and sets the enable bit. The block then hands descriptor addresses one at a time to a separate execution engine through a start/done handshake, and follows each finished descriptor's next pointer until it meets a zero pointer. Moving the data is the engine's job and lies outside this block.

A chain that has ended can be resumed without a restart. Software links more descriptors onto the tail and sets the append bit. The block then asks the engine's link port to re-read the next pointer of the last descriptor. If that pointer is non-zero, the chain continues from it. The status word combines a live busy bit with sticky, write-one-to-clear flags for end of transfer, end of chain and four error causes. The interrupt line is high while a flag is set whose causing descriptor asked for an interrupt.

The sequencer has five states: `S_IDLE` (stopped), `S_LAUNCH` (one-cycle start to the engine), `S_RUN` (waiting for the engine), `S_END` (chain ended, enable still set) and `S_RELINK` (waiting for the re-read next pointer). The transitions are:
- IDLE->LAUNCH on a rising enable.
- LAUNCH->RUN always.
- RUN->LAUNCH on done with a non-zero next pointer.
- RUN->END on done with a zero pointer.
- RUN->RELINK on done with a zero pointer and append pending.
- RUN->IDLE on done with an error or with enable clear.
- END->RELINK on append.
- END->IDLE on enable clear.
- RELINK->LAUNCH on acknowledge with a non-zero pointer.
- RELINK->END on acknowledge with a zero pointer.
- RELINK->IDLE on acknowledge with enable clear.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads 0, and `irq`, `eng_start` and `lnk_req` are low.
- R2: Register offsets are: control 0x00 (bit 0 enable, bit 1 append), status 0x04, current descriptor 0x08 (read-only), next descriptor 0x24, byte count 0x30 (read-only). Status bits are: 13 busy, 12 end of transfer, 11 end of chain, 9 parity error, 5 memory-controller abort, 4 target abort, 3 master abort. All other bits read 0.
- R3: A write that takes enable from 0 to 1 while idle copies the next-descriptor register into the current-descriptor register. It drives `eng_start` high for exactly the following cycle, with that address on `eng_desc`. Busy reads 1 from then on.
- R4: An `eng_done` without error and with a non-zero `eng_next` sets end of transfer. It loads `eng_next` into the current-descriptor register and issues a new one-cycle start.
- R5: An `eng_done` without error and with `eng_next` zero sets both end of transfer and end of chain, and busy reads 0.
- R6: In the end-of-chain state, setting append raises `lnk_req` with the current descriptor address on `lnk_addr`, held until `lnk_ack`. A non-zero `lnk_ptr` becomes the current descriptor and is started; a zero pointer returns the channel to the end-of-chain state. In both cases the append bit reads 0 afterwards.
- R7: An `eng_done` with `eng_err` sets the status bits selected by `eng_err_code` (code bit 3 to bit 9, bit 2 to bit 5, bit 1 to bit 4, bit 0 to bit 3) and stops the channel to idle, with busy 0.
- R8: Clearing enable while a descriptor runs lets it finish. No further start follows, and the channel goes idle.
- R9: Writing 1 to a status flag clears it, and writing 0 leaves it unchanged. If a set and a clear meet in the same cycle, the flag stays set.
- R10: Writes to the current-descriptor register, the byte-count register and the busy bit are ignored.
- R11: `irq` is high exactly while a status flag is set whose setting event came with `eng_irq_req` high.
- R12: The byte-count register captures `eng_bytes` at every `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_start | output | 1 | One-cycle start to the execution engine |
| eng_desc | output | 32 | Descriptor address for the engine |
| eng_done | input | 1 | Engine finished the current descriptor |
| eng_err | input | 1 | The finished descriptor ended in error |
| eng_err_code | input | 4 | Error causes: parity, memory abort, target abort, master abort |
| eng_next | input | 32 | Next pointer of the finished descriptor |
| eng_bytes | input | 24 | Byte count of the finished descriptor |
| eng_irq_req | input | 1 | The finished descriptor requested an interrupt |
| lnk_req | output | 1 | Request to re-read the next pointer at `lnk_addr` |
| lnk_addr | output | 32 | Descriptor whose next pointer is re-read |
| lnk_ack | input | 1 | Re-read pointer is valid |
| lnk_ptr | input | 32 | Re-read next pointer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine raises `eng_done` for exactly one cycle and only while a descriptor is outstanding. They also assume that `eng_err_code`, `eng_next`, `eng_bytes` and `eng_irq_req` are valid in that cycle. They likewise assume that `lnk_ack` is a single-cycle reply that comes only while `lnk_req` is high. The bench acts as that engine and link port. It drives every such pulse for one cycle, from the falling edge, and only after it has seen the matching start or link request at the ports.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    // register byte offsets
    localparam logic [5:0] OFF_CTRL  = 6'h00;
    localparam logic [5:0] OFF_STAT  = 6'h04;
    localparam logic [5:0] OFF_CUR   = 6'h08;
    localparam logic [5:0] OFF_NEXT  = 6'h24;
    localparam logic [5:0] OFF_BYTES = 6'h30;

    // control bit positions
    localparam int CTL_EN  = 0;
    localparam int CTL_APP = 1;

    // status bit positions
    localparam int STB_BUSY = 13;
    localparam int STB_EOT  = 12;
    localparam int STB_EOC  = 11;
    localparam int STB_PAR  = 9;
    localparam int STB_MCA  = 5;
    localparam int STB_TGT  = 4;
    localparam int STB_MST  = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH,
        S_RUN,
        S_END,
        S_RELINK
    } chan_state_e;

endpackage

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_regs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          en_rise_i,
    input  logic          app_i,
    input  logic [AW-1:0] nxt_i,
    input  logic          done_i,
    input  logic          err_i,
    input  logic [AW-1:0] done_next_i,
    input  logic          lnk_ack_i,
    input  logic [AW-1:0] lnk_ptr_i,
    output logic          start_o,
    output logic          busy_o,
    output logic          lnk_req_o,
    output logic [AW-1:0] cur_o,
    output logic          app_clr_o,
    output logic          ev_eot_o,
    output logic          ev_eoc_o,
    output logic          ev_err_o
);

    chan_state_e   state_q, state_d;
    logic          cur_load;
    logic [AW-1:0] cur_src;
    logic [AW-1:0] cur_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // current descriptor register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cur_q <= '0;
        else if (cur_load) cur_q <= cur_src;
    end

    // next state
    always_comb begin
        state_d  = state_q;
        cur_load = 1'b0;
        cur_src  = nxt_i;
        unique case (state_q)
            S_IDLE: begin
                if (en_rise_i) begin
                    state_d  = S_LAUNCH;
                    cur_load = 1'b1;
                end
            end
            S_LAUNCH: state_d = S_RUN;
            S_RUN: begin
                if (done_i) begin
                    if (err_i || !en_i) begin
                        state_d = S_IDLE;
                    end else if (done_next_i != '0) begin
                        state_d  = S_LAUNCH;
                        cur_load = 1'b1;
                        cur_src  = done_next_i;
                    end else if (app_i) begin
                        state_d = S_RELINK;
                    end else begin
                        state_d = S_END;
                    end
                end
            end
            S_END: begin
                if (!en_i)      state_d = S_IDLE;
                else if (app_i) state_d = S_RELINK;
            end
            S_RELINK: begin
                if (lnk_ack_i) begin
                    if (!en_i) begin
                        state_d = S_IDLE;
                    end else if (lnk_ptr_i != '0) begin
                        state_d  = S_LAUNCH;
                        cur_load = 1'b1;
                        cur_src  = lnk_ptr_i;
                    end else begin
                        state_d = S_END;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_o   = (state_q == S_LAUNCH);
        lnk_req_o = (state_q == S_RELINK);
        busy_o    = (state_q == S_LAUNCH) || (state_q == S_RUN) || (state_q == S_RELINK);
        app_clr_o = (state_q == S_IDLE) || ((state_q == S_RELINK) && lnk_ack_i);
        ev_eot_o  = (state_q == S_RUN) && done_i && !err_i;
        ev_eoc_o  = (state_q == S_RUN) && done_i && !err_i && (done_next_i == '0);
        ev_err_o  = (state_q == S_RUN) && done_i && err_i;
    end

    assign cur_o = cur_q;

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R6
    lnk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req_o && !lnk_ack_i) |=> lnk_req_o);

    // R7
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && done_i && err_i) |=> !busy_o);

    // R8
    disable_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && done_i && !en_i) |=> !start_o);

endmodule

// File: rtl/dma_evt_flags.sv
module dma_evt_flags #(
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_eot_i,
    input  logic          set_eoc_i,
    input  logic          set_err_i,
    input  logic [EW-1:0] err_code_i,
    input  logic          irq_req_i,
    input  logic          clr_eot_i,
    input  logic          clr_eoc_i,
    input  logic [EW-1:0] clr_err_i,
    output logic          eot_o,
    output logic          eoc_o,
    output logic [EW-1:0] err_o,
    output logic          irq_o
);

    logic          eot_q, eoc_q;
    logic [EW-1:0] err_q;
    logic          tag_eot_q, tag_eoc_q, tag_err_q;
    logic          eot_d, eoc_d;
    logic [EW-1:0] err_d;

    // set has priority over a same-cycle clear
    always_comb begin
        eot_d = (eot_q & ~clr_eot_i) | set_eot_i;
        eoc_d = (eoc_q & ~clr_eoc_i) | set_eoc_i;
        err_d = (err_q & ~clr_err_i) | ({EW{set_err_i}} & err_code_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eot_q     <= 1'b0;
            eoc_q     <= 1'b0;
            err_q     <= '0;
            tag_eot_q <= 1'b0;
            tag_eoc_q <= 1'b0;
            tag_err_q <= 1'b0;
        end else begin
            eot_q     <= eot_d;
            eoc_q     <= eoc_d;
            err_q     <= err_d;
            tag_eot_q <= eot_d & ((tag_eot_q & eot_q) | (set_eot_i & irq_req_i));
            tag_eoc_q <= eoc_d & ((tag_eoc_q & eoc_q) | (set_eoc_i & irq_req_i));
            tag_err_q <= (|err_d) & ((tag_err_q & (|err_q)) | (set_err_i & irq_req_i));
        end
    end

    assign eot_o = eot_q;
    assign eoc_o = eoc_q;
    assign err_o = err_q;
    assign irq_o = (eot_q & tag_eot_q) | (eoc_q & tag_eoc_q) | ((|err_q) & tag_err_q);

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (eot_q || eoc_q || (err_q != '0)));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_eot_i |=> eot_q);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 32,
    parameter int BCW  = 24,
    parameter int OFFW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [OFFW-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            eng_start,
    output logic [AW-1:0]   eng_desc,
    input  logic            eng_done,
    input  logic            eng_err,
    input  logic [3:0]      eng_err_code,
    input  logic [AW-1:0]   eng_next,
    input  logic [BCW-1:0]  eng_bytes,
    input  logic            eng_irq_req,
    output logic            lnk_req,
    output logic [AW-1:0]   lnk_addr,
    input  logic            lnk_ack,
    input  logic [AW-1:0]   lnk_ptr,
    output logic            irq
);

    localparam int EW = 4;

    logic           wr_ctl, wr_sts, wr_nxt;
    logic           ctl_en_q, ctl_app_q;
    logic [AW-1:0]  nxt_q;
    logic [BCW-1:0] bytes_q;
    logic           en_rise, app_clr, busy;
    logic [AW-1:0]  cur;
    logic           ev_eot, ev_eoc, ev_err;
    logic           f_eot, f_eoc;
    logic [EW-1:0]  f_err, clr_err;

    always_comb begin
        wr_ctl  = reg_wr && (reg_addr == OFFW'(OFF_CTRL));
        wr_sts  = reg_wr && (reg_addr == OFFW'(OFF_STAT));
        wr_nxt  = reg_wr && (reg_addr == OFFW'(OFF_NEXT));
        en_rise = wr_ctl && reg_wdata[CTL_EN] && !ctl_en_q;
        clr_err = {EW{wr_sts}} & {reg_wdata[STB_PAR], reg_wdata[STB_MCA],
                                  reg_wdata[STB_TGT], reg_wdata[STB_MST]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en_q  <= 1'b0;
            ctl_app_q <= 1'b0;
            nxt_q     <= '0;
            bytes_q   <= '0;
        end else begin
            if (wr_ctl) ctl_en_q <= reg_wdata[CTL_EN];
            ctl_app_q <= (ctl_app_q | (wr_ctl & reg_wdata[CTL_APP])) & ~app_clr;
            if (wr_nxt) nxt_q <= reg_wdata[AW-1:0];
            if (ev_eot || ev_err) bytes_q <= eng_bytes;
        end
    end

    dma_chan_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctl_en_q),
        .en_rise_i  (en_rise),
        .app_i      (ctl_app_q),
        .nxt_i      (nxt_q),
        .done_i     (eng_done),
        .err_i      (eng_err),
        .done_next_i(eng_next),
        .lnk_ack_i  (lnk_ack),
        .lnk_ptr_i  (lnk_ptr),
        .start_o    (eng_start),
        .busy_o     (busy),
        .lnk_req_o  (lnk_req),
        .cur_o      (cur),
        .app_clr_o  (app_clr),
        .ev_eot_o   (ev_eot),
        .ev_eoc_o   (ev_eoc),
        .ev_err_o   (ev_err)
    );

    dma_evt_flags #(.EW(EW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_eot_i (ev_eot),
        .set_eoc_i (ev_eoc),
        .set_err_i (ev_err),
        .err_code_i(eng_err_code),
        .irq_req_i (eng_irq_req),
        .clr_eot_i (wr_sts && reg_wdata[STB_EOT]),
        .clr_eoc_i (wr_sts && reg_wdata[STB_EOC]),
        .clr_err_i (clr_err),
        .eot_o     (f_eot),
        .eoc_o     (f_eoc),
        .err_o     (f_err),
        .irq_o     (irq)
    );

    assign eng_desc = cur;
    assign lnk_addr = cur;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFFW'(OFF_CTRL): begin
                reg_rdata[CTL_EN]  = ctl_en_q;
                reg_rdata[CTL_APP] = ctl_app_q;
            end
            OFFW'(OFF_STAT): begin
                reg_rdata[STB_BUSY] = busy;
                reg_rdata[STB_EOT]  = f_eot;
                reg_rdata[STB_EOC]  = f_eoc;
                reg_rdata[STB_PAR]  = f_err[3];
                reg_rdata[STB_MCA]  = f_err[2];
                reg_rdata[STB_TGT]  = f_err[1];
                reg_rdata[STB_MST]  = f_err[0];
            end
            OFFW'(OFF_CUR):   reg_rdata = DW'(cur);
            OFFW'(OFF_NEXT):  reg_rdata = DW'(nxt_q);
            OFFW'(OFF_BYTES): reg_rdata = DW'(bytes_q);
            default:          reg_rdata = '0;
        endcase
    end

    // R6
    app_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && lnk_ack) |=> !ctl_app_q);

    // R12
    bytes_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && (busy && !eng_start && !lnk_req)) |=> (bytes_q == $past(eng_bytes)));

endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_start;
    logic [31:0] eng_desc;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic [3:0]  eng_err_code = '0;
    logic [31:0] eng_next = '0;
    logic [23:0] eng_bytes = '0;
    logic        eng_irq_req = 1'b0;
    logic        lnk_req;
    logic [31:0] lnk_addr;
    logic        lnk_ack = 1'b0;
    logic [31:0] lnk_ptr = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_desc(eng_desc), .eng_done(eng_done), .eng_err(eng_err),
        .eng_err_code(eng_err_code), .eng_next(eng_next), .eng_bytes(eng_bytes),
        .eng_irq_req(eng_irq_req), .lnk_req(lnk_req), .lnk_addr(lnk_addr),
        .lnk_ack(lnk_ack), .lnk_ptr(lnk_ptr), .irq(irq)
    );

    localparam logic [5:0] A_CTL = 6'h00, A_STS = 6'h04, A_CUR = 6'h08,
                           A_NXT = 6'h24, A_BC = 6'h30;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic done(input logic [31:0] nxt, input logic [23:0] bc,
                        input logic irqr, input logic er, input logic [3:0] code);
        eng_done = 1'b1; eng_next = nxt; eng_bytes = bc;
        eng_irq_req = irqr; eng_err = er; eng_err_code = code;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0; eng_irq_req = 1'b0; eng_err_code = '0;
    endtask

    task automatic ack(input logic [31:0] p);
        lnk_ack = 1'b1; lnk_ptr = p;
        @(negedge clk);
        lnk_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTL, v); chk("R1 ctrl", v, 0);
        rd(A_STS, v); chk("R1 status", v, 0);
        rd(A_CUR, v); chk("R1 cur", v, 0);
        rd(A_NXT, v); chk("R1 next", v, 0);
        rd(A_BC, v);  chk("R1 bytes", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 start", {31'd0, eng_start}, 0);
        chk("R1 lnk_req", {31'd0, lnk_req}, 0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(A_CUR, 32'hDEAD_BEEF);
        rd(A_CUR, v); chk("R10 cur ignores write", v, 0);
        wr(A_BC, 32'hFFFF_FFFF);
        rd(A_BC, v); chk("R10 bytes ignore write", v, 0);
        wr(A_STS, 32'h0000_2000);
        rd(A_STS, v); chk("R10 busy ignores write", v, 0);
    endtask

    task automatic t_start_chain();
        logic [31:0] v;
        wr(A_NXT, 32'h0000_0100);
        rd(A_NXT, v); chk("R2 next reg", v, 32'h100);
        wr(A_CTL, 32'h1);
        chk("R3 start pulse", {31'd0, eng_start}, 1);
        chk("R3 desc addr", eng_desc, 32'h100);
        rd(A_CUR, v); chk("R3 cur loaded", v, 32'h100);
        rd(A_STS, v); chk("R3 busy", v, 32'h2000);
        step();
        chk("R3 start one cycle", {31'd0, eng_start}, 0);
        done(32'h200, 24'h40, 1'b0, 1'b0, 4'h0);
        chk("R4 restart", {31'd0, eng_start}, 1);
        chk("R4 next desc", eng_desc, 32'h200);
        rd(A_STS, v); chk("R4 eot+busy", v, 32'h3000);
        chk("R11 no irq untagged", {31'd0, irq}, 0);
        rd(A_BC, v); chk("R12 bytes first", v, 32'h40);
        step();
        // done with zero next; same cycle software clears end of transfer
        reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = 32'h1000;
        done(32'h0, 24'h80, 1'b1, 1'b0, 4'h0);
        reg_wr = 1'b0;
        rd(A_STS, v); chk("R5 R9 chain end, set wins", v, 32'h1800);
        chk("R11 irq tagged", {31'd0, irq}, 1);
        rd(A_BC, v); chk("R12 bytes second", v, 32'h80);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_STS, 32'h0);
        rd(A_STS, v); chk("R9 write zero no effect", v, 32'h1800);
        wr(A_STS, 32'h1000);
        rd(A_STS, v); chk("R9 clear eot", v, 32'h0800);
        chk("R11 irq via eoc", {31'd0, irq}, 1);
        wr(A_STS, 32'h0800);
        rd(A_STS, v); chk("R9 clear eoc", v, 0);
        chk("R11 irq drops", {31'd0, irq}, 0);
    endtask

    task automatic t_append();
        logic [31:0] v;
        wr(A_CTL, 32'h3);
        step();
        chk("R6 lnk_req", {31'd0, lnk_req}, 1);
        chk("R6 lnk_addr", lnk_addr, 32'h200);
        step();
        chk("R6 lnk_req held", {31'd0, lnk_req}, 1);
        ack(32'h300);
        chk("R6 resume start", {31'd0, eng_start}, 1);
        chk("R6 resume addr", eng_desc, 32'h300);
        rd(A_CTL, v); chk("R6 append self-clear", v, 32'h1);
        step();
        done(32'h0, 24'h10, 1'b0, 1'b0, 4'h0);
        rd(A_STS, v); chk("R5 end again", v, 32'h1800);
        wr(A_STS, 32'h1800);
        wr(A_CTL, 32'h3);
        step();
        ack(32'h0);
        chk("R6 zero ptr no start", {31'd0, eng_start}, 0);
        rd(A_STS, v); chk("R6 zero ptr not busy", v, 0);
        rd(A_CTL, v); chk("R6 append cleared", v, 32'h1);
        rd(A_CUR, v); chk("R6 cur kept", v, 32'h300);
        wr(A_CTL, 32'h0);
        step();
    endtask

    task automatic t_error();
        logic [31:0] v;
        wr(A_NXT, 32'h500);
        wr(A_CTL, 32'h1);
        step();
        done(32'h700, 24'h20, 1'b1, 1'b1, 4'b1001);
        rd(A_STS, v); chk("R7 error bits 9,3", v, 32'h0208);
        chk("R7 no restart", {31'd0, eng_start}, 0);
        chk("R11 irq error", {31'd0, irq}, 1);
        wr(A_STS, 32'h0200);
        rd(A_STS, v); chk("R9 clear one error", v, 32'h0008);
        wr(A_STS, 32'h0008);
        chk("R11 irq error cleared", {31'd0, irq}, 0);
        wr(A_CTL, 32'h0);
        wr(A_CTL, 32'h1);
        step();
        done(32'h0, 24'h20, 1'b0, 1'b1, 4'b0110);
        rd(A_STS, v); chk("R7 error bits 5,4", v, 32'h0030);
        wr(A_STS, 32'h0030);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(A_CTL, 32'h1);
        step();
        wr(A_CTL, 32'h0);
        done(32'h600, 24'h8, 1'b0, 1'b0, 4'h0);
        chk("R8 no further start", {31'd0, eng_start}, 0);
        rd(A_STS, v); chk("R8 idle with eot only", v, 32'h1000);
        rd(A_CUR, v); chk("R8 cur unchanged", v, 32'h500);
        step();
        chk("R8 still no start", {31'd0, eng_start}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_readonly();
        t_start_chain();
        t_w1c();
        t_append();
        t_error();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule